// File: doc/BRIEF.md
# Upstream-Link-Down Packet Disposition Filter

This block makes one decision for each transaction that crosses a switch partition. The decision covers the case where the partition's upstream data link has gone down and the reset that a lost link would normally cause has been suppressed by configuration. When both of those conditions hold, packets aimed at the dead upstream link cannot be delivered. The block picks one of three outcomes for each packet: pass it on, complete it as an unsupported request, or discard it without a response. The choice depends on where the packet came in and where it is headed. Peer-to-peer traffic is never touched.

Each transaction arrives with a valid/ready handshake. It carries a 2-bit ingress source, a flag that says whether its destination is the upstream link, and an opaque tag. The decision and the tag come out one register stage later on a second valid/ready handshake. When the consumer stalls, the input is held back. Three saturating counters keep a running total of the transactions accepted with each outcome.

Top module: `updn_disp_filter`

## Requirements
- R1: When `link_down_i` is low or `hrst_dis_i` is low at acceptance, the disposition is forward (code 0), whatever the source and destination.
- R2: With the filter active (both `link_down_i` and `hrst_dis_i` high), a packet from source 0 (bridge secondary side) with `in_to_up` high gets unsupported request (code 1).
- R3: With the filter active, a packet from source 1 (non-transparent function of another partition) with `in_to_up` high gets unsupported request (code 1).
- R4: With the filter active, a packet from source 2 (DMA engine) with `in_to_up` high gets drop (code 2).
- R5: With the filter active, a packet from source 3 (locally generated root-bound message) gets drop (code 2), whatever the value of `in_to_up`.
- R6: With the filter active, a packet from source 0, 1 or 2 with `in_to_up` low gets forward (code 0).
- R7: A transaction accepted at a clock edge appears at that same edge on `out_valid` with its disposition, and its tag is passed through unchanged. `out_valid` falls after a handshake on the output unless a new transaction is accepted in that cycle.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_disp` and `out_tag` hold steady. Otherwise `in_ready` is high.
- R9: `cnt_fwd`, `cnt_ur` and `cnt_drop` each increase by one at the edge where a transaction with disposition 0, 1 or 2 respectively is accepted.
- R10: Each counter stops at its all-ones value and stays there.
- R11: During and after reset, `out_valid` is 0, `in_ready` is 1 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_down_i | input | 1 | Upstream data link is down |
| hrst_dis_i | input | 1 | Link-down reset is suppressed |
| in_valid | input | 1 | Input transaction valid |
| in_ready | output | 1 | Input transaction accepted when high with valid |
| in_src | input | 2 | Ingress source: 0 bridge, 1 foreign NT, 2 DMA, 3 local message |
| in_to_up | input | 1 | Destination is the upstream link |
| in_tag | input | TAG_W | Opaque transaction tag |
| out_valid | output | 1 | Decision valid |
| out_ready | input | 1 | Consumer takes the decision |
| out_disp | output | 2 | 0 forward, 1 unsupported request, 2 drop |
| out_tag | output | TAG_W | Tag of the decided transaction |
| cnt_fwd | output | CNT_W | Forwarded count, saturating |
| cnt_ur | output | CNT_W | Unsupported-request count, saturating |
| cnt_drop | output | CNT_W | Dropped count, saturating |

## Verification
The hardest case to reach is a counter sitting at its ceiling while further transactions of the same outcome keep arriving. That case has to be checked together with a stalled output register, which must hold its decision while the link-state inputs change underneath it. The bench builds its instance with narrow counters so that the long random run drives the forward count to its limit. A directed burst of DMA packets to the upstream link then fills the drop counter. Random `out_ready` and link-state toggling cover stalls that overlap a change in filter activation.

// File: rtl/udf_pkg.sv
package udf_pkg;
  localparam logic [1:0] SRC_BRIDGE = 2'd0;
  localparam logic [1:0] SRC_XNT    = 2'd1;
  localparam logic [1:0] SRC_DMA    = 2'd2;
  localparam logic [1:0] SRC_LMSG   = 2'd3;

  localparam logic [1:0] DISP_FWD  = 2'd0;
  localparam logic [1:0] DISP_UR   = 2'd1;
  localparam logic [1:0] DISP_DROP = 2'd2;

  localparam int N_DISP = 3;

  function automatic logic [1:0] pick_disp(input logic active,
                                           input logic [1:0] src,
                                           input logic to_up);
    logic [1:0] d;
    d = DISP_FWD;
    if (active) begin
      if (src == SRC_LMSG)                 d = DISP_DROP;
      else if (to_up && src == SRC_DMA)    d = DISP_DROP;
      else if (to_up)                      d = DISP_UR;
    end
    return d;
  endfunction
endpackage

// File: rtl/udf_classify.sv
module udf_classify
  import udf_pkg::*;
(
  input  logic       link_down,
  input  logic       rst_suppress,
  input  logic [1:0] src,
  input  logic       to_up,
  output logic       filter_on,
  output logic [1:0] disp
);
  assign filter_on = link_down && rst_suppress;
  assign disp      = pick_disp(filter_on, src, to_up);
endmodule

// File: rtl/udf_stage.sv
module udf_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data,
  output logic         take
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign up_ready = !v_q || dn_ready;
  assign take     = up_valid && up_ready;
  assign dn_valid = v_q;
  assign dn_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (take) begin
      v_q <= 1'b1;
      d_q <= up_data;
    end else if (dn_ready) begin
      v_q <= 1'b0;
    end
  end
endmodule

// File: rtl/udf_satcnt.sv
module udf_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] c_q;

  assign count = c_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  c_q <= '0;
    else if (bump && c_q != TOP) c_q <= c_q + W'(1);
  end
endmodule

// File: rtl/updn_disp_filter.sv
module updn_disp_filter
  import udf_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_down_i,
  input  logic             hrst_dis_i,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_src,
  input  logic             in_to_up,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_disp,
  output logic [TAG_W-1:0] out_tag,
  output logic [CNT_W-1:0] cnt_fwd,
  output logic [CNT_W-1:0] cnt_ur,
  output logic [CNT_W-1:0] cnt_drop
);
  localparam int PW = TAG_W + 2;

  logic          filter_on;
  logic [1:0]    cls_disp;
  logic          accept;
  logic [PW-1:0] stage_out;
  logic [CNT_W-1:0] cnt_arr [N_DISP];

  udf_classify cls_i (
    .link_down    (link_down_i),
    .rst_suppress (hrst_dis_i),
    .src          (in_src),
    .to_up        (in_to_up),
    .filter_on    (filter_on),
    .disp         (cls_disp)
  );

  udf_stage #(.W(PW)) stg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({cls_disp, in_tag}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (stage_out),
    .take     (accept)
  );

  assign out_disp = stage_out[PW-1 -: 2];
  assign out_tag  = stage_out[TAG_W-1:0];

  for (genvar k = 0; k < N_DISP; k++) begin : g_cnt
    localparam logic [1:0] CODE = 2'(k);
    logic bump_k;
    assign bump_k = accept && (cls_disp == CODE);
    udf_satcnt #(.W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (bump_k),
      .count (cnt_arr[k])
    );
  end

  assign cnt_fwd  = cnt_arr[0];
  assign cnt_ur   = cnt_arr[1];
  assign cnt_drop = cnt_arr[2];
endmodule

// File: rtl/udf_checker.sv
module udf_checker
  import udf_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             filter_on,
  input logic             in_ready,
  input logic [1:0]       in_src,
  input logic             in_to_up,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_disp,
  input logic [TAG_W-1:0] out_tag,
  input logic [CNT_W-1:0] cnt_fwd,
  input logic [CNT_W-1:0] cnt_ur,
  input logic [CNT_W-1:0] cnt_drop
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_idle_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !filter_on) |=> out_disp == DISP_FWD);
  assert_bridge_ur_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && filter_on && in_src == SRC_BRIDGE && in_to_up) |=> out_disp == DISP_UR);
  assert_xnt_ur_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && filter_on && in_src == SRC_XNT && in_to_up) |=> out_disp == DISP_UR);
  assert_dma_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && filter_on && in_src == SRC_DMA && in_to_up) |=> out_disp == DISP_DROP);
  assert_lmsg_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && filter_on && in_src == SRC_LMSG) |=> out_disp == DISP_DROP);
  assert_peer_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_src != SRC_LMSG && !in_to_up) |=> out_disp == DISP_FWD);
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_disp) && $stable(out_tag)));
  assert_fwd_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_fwd == $past(cnt_fwd) || cnt_fwd == $past(cnt_fwd) + CNT_W'(1)));
  assert_ur_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_ur == $past(cnt_ur) || cnt_ur == $past(cnt_ur) + CNT_W'(1)));
  assert_drop_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_drop == $past(cnt_drop) || cnt_drop == $past(cnt_drop) + CNT_W'(1)));
  assert_fwd_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fwd == CMAX) |=> cnt_fwd == CMAX);
  assert_drop_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_drop == CMAX) |=> cnt_drop == CMAX);
endmodule

bind updn_disp_filter udf_checker #(.TAG_W(TAG_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .filter_on (filter_on),
  .in_ready  (in_ready),
  .in_src    (in_src),
  .in_to_up  (in_to_up),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_disp  (out_disp),
  .out_tag   (out_tag),
  .cnt_fwd   (cnt_fwd),
  .cnt_ur    (cnt_ur),
  .cnt_drop  (cnt_drop)
);

// File: tb/updn_disp_filter_tb.sv
module updn_disp_filter_tb_top;
  localparam int CLK_P = 10;
  localparam int TW    = 8;
  localparam int CW    = 6;
  localparam logic [CW-1:0] CTOP = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_down_i = 1'b0, hrst_dis_i = 1'b0;
  logic in_valid = 1'b0, in_to_up = 1'b0, out_ready = 1'b0;
  logic [1:0] in_src = 2'd0;
  logic [TW-1:0] in_tag = '0;
  logic in_ready, out_valid;
  logic [1:0] out_disp;
  logic [TW-1:0] out_tag;
  logic [CW-1:0] cnt_fwd, cnt_ur, cnt_drop;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic          m_valid = 1'b0;
  logic [1:0]    m_disp = 2'd0;
  logic [TW-1:0] m_tag = '0;
  string         m_req = "R7";
  logic [CW-1:0] m_cnt [3] = '{default: '0};

  always #(CLK_P/2) clk = ~clk;

  updn_disp_filter #(.TAG_W(TW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .link_down_i(link_down_i), .hrst_dis_i(hrst_dis_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_to_up(in_to_up),
    .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
    .out_disp(out_disp), .out_tag(out_tag),
    .cnt_fwd(cnt_fwd), .cnt_ur(cnt_ur), .cnt_drop(cnt_drop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outcome written from the requirement list
  function automatic logic [1:0] want_disp(input logic ld, input logic dis,
                                           input logic [1:0] s, input logic u);
    if (!(ld && dis)) return 2'd0;
    case (s)
      2'd3:    return 2'd2;
      2'd2:    return u ? 2'd2 : 2'd0;
      default: return u ? 2'd1 : 2'd0;
    endcase
  endfunction

  function automatic string which_req(input logic ld, input logic dis,
                                      input logic [1:0] s, input logic u);
    if (!(ld && dis)) return "R1";
    if (s == 2'd3)    return "R5";
    if (!u)           return "R6";
    if (s == 2'd0)    return "R2";
    if (s == 2'd1)    return "R3";
    return "R4";
  endfunction

  task automatic compare_outputs();
    chk(out_valid == m_valid, "R7 valid", int'(out_valid), int'(m_valid));
    if (m_valid) begin
      chk(out_disp == m_disp, m_req, int'(out_disp), int'(m_disp));
      chk(out_tag == m_tag, "R7 tag", int'(out_tag), int'(m_tag));
    end
    chk(cnt_fwd  == m_cnt[0], (m_cnt[0] == CTOP) ? "R10 fwd"  : "R9 fwd",  int'(cnt_fwd),  int'(m_cnt[0]));
    chk(cnt_ur   == m_cnt[1], (m_cnt[1] == CTOP) ? "R10 ur"   : "R9 ur",   int'(cnt_ur),   int'(m_cnt[1]));
    chk(cnt_drop == m_cnt[2], (m_cnt[2] == CTOP) ? "R10 drop" : "R9 drop", int'(cnt_drop), int'(m_cnt[2]));
  endtask

  task automatic step(input logic v, input logic [1:0] s, input logic u,
                      input logic [TW-1:0] t, input logic ordy,
                      input logic ld, input logic dis);
    logic exp_rdy;
    logic [1:0] d;
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_src = s; in_to_up = u; in_tag = t;
    out_ready = ordy; link_down_i = ld; hrst_dis_i = dis;
    #1;
    exp_rdy = !m_valid || ordy;
    chk(in_ready == exp_rdy, "R8 ready", int'(in_ready), int'(exp_rdy));
    @(posedge clk);
    if (v && exp_rdy) begin
      d = want_disp(ld, dis, s, u);
      m_valid = 1'b1; m_disp = d; m_tag = t; m_req = which_req(ld, dis, s, u);
      if (m_cnt[d] != CTOP) m_cnt[d] = m_cnt[d] + 1'b1;
    end else if (ordy) begin
      m_valid = 1'b0;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005eed1));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11 valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11 ready", int'(in_ready), 1);
    chk(cnt_fwd == '0 && cnt_ur == '0 && cnt_drop == '0, "R11 counters",
        int'(cnt_fwd) + int'(cnt_ur) + int'(cnt_drop), 0);
    rst_n = 1'b1;

    // directed: every source and destination with the filter active (R2..R6)
    for (int s = 0; s < 4; s++)
      for (int u = 0; u < 2; u++)
        step(1'b1, 2'(s), 1'(u), TW'(s * 2 + u + 1), 1'b1, 1'b1, 1'b1);
    // directed: filter inactive in each partial condition (R1)
    step(1'b1, 2'd2, 1'b1, 8'h21, 1'b1, 1'b1, 1'b0);
    step(1'b1, 2'd3, 1'b0, 8'h22, 1'b1, 1'b0, 1'b1);
    step(1'b1, 2'd0, 1'b1, 8'h23, 1'b1, 1'b0, 1'b0);
    // directed stall: output held while link state flips (R8)
    step(1'b1, 2'd1, 1'b1, 8'h30, 1'b0, 1'b1, 1'b1);
    step(1'b1, 2'd2, 1'b1, 8'h31, 1'b0, 1'b0, 1'b0);
    step(1'b1, 2'd3, 1'b1, 8'h32, 1'b0, 1'b1, 1'b1);
    step(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    step(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);

    // constrained random run
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 5) != 0, 2'($urandom % 4), 1'($urandom % 2),
           TW'($urandom), ($urandom % 4) != 0,
           ($urandom % 4) != 0, ($urandom % 4) != 0);
    end

    // fill and hold the drop counter at its ceiling (R4, R10)
    for (int i = 0; i < 70; i++)
      step(1'b1, 2'd2, 1'b1, TW'(i), 1'b1, 1'b1, 1'b1);
    step(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'd0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule